// File: doc/BRIEF.md
# Video Address Counter with Line-Start Reload

This block produces the character-memory address for a text-mode display controller. A 14-bit running pointer advances once per character clock across the visible part of each raster line. A single shadow copy of that pointer remembers where the current character row began, so every raster line of the row can fetch the same characters again. Once per frame, the pointer restarts from a programmable 14-bit start address held in two byte-wide registers.

Software reaches the registers through an indirect port. One write strobe latches a register index, and a second strobe stores a data byte into the register that index selects. Four timing registers set the line length, the visible width, the rows per frame and the lines per row. A static two-bit variant select chooses among controller flavours that differ only in when the pointer and its shadow are reloaded, and from which source. Software that must run on every flavour therefore has to update the start address outside the first character row.

Top module: `vaddr_reload`

## Requirements
- R1: While reset is high, and on the first cycle after it, the address output is 0, all counters are 0, the start address is 0 and the timing registers hold their parameter defaults (line end 7, visible width 4, last row 3, last line 2).
- R2: A cycle with `reg_sel_we` high latches `reg_wdata[4:0]` as the register index. A cycle with `reg_data_we` high stores `reg_wdata` into the selected register. The indices are 0 = last character of a line, 1 = visible width, 4 = last row of a frame, 9 = last raster line of a row, 12 = start address bits 13:8 (taken from `reg_wdata[5:0]`) and 13 = start address bits 7:0. A write takes effect on the following cycle.
- R3: The character counter runs from 0 to the value of register 0 and then wraps. The line counter advances on each such wrap and returns to 0 after the value of register 9. The row counter advances on each line-counter wrap and returns to 0 after the value of register 4. The cycle in which all three counters are 0 is the first cycle of a frame.
- R4: On each clock with the character count below register 1 that is not the last character of the line, the address rises by one, modulo 2^14. From the count equal to register 1 up to the end of the line it holds its value.
- R5: On the last raster line of each row, at the clock where the character count equals register 1, the shadow register takes the current address. The one exception is the last row of the frame in variant 2 (see R9).
- R6: At every line start that is not a frame start, the address is reloaded from the shadow register. Variant 1 on row 0 is the exception (R8).
- R7: In variants 0 and 3, at a frame start both the address and the shadow are loaded from the start address. A start-address write made during a frame is therefore first seen at the next frame start.
- R8: In variant 1, at every line start that begins a line of row 0, the address is loaded from the start address, and at a frame start the shadow is loaded from it too. A write made during row 0 shows on the next line.
- R9: In variant 2, the address is loaded from the shadow at every line start, frame start included. On the last row of a frame, the capture point of R5 loads the shadow from the start address rather than from the address.
- R10: When a start-address write lands on the same clock as a line-start reload, the reload uses the start address held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 2 | Static controller variant (0..3) |
| reg_sel_we | input | 1 | Latch register index from `reg_wdata[4:0]` |
| reg_data_we | input | 1 | Write `reg_wdata` into the selected register |
| reg_wdata | input | 8 | Register port data |
| vid_addr | output | 14 | Video memory address |

## Verification
The collision of interest is a start-address data write in the same clock as a line-start or frame-start reload. In that clock the pointer loads from the register pair while the pair is changing. The bench provokes this by timing the data strobe against its own model's character count, so that the strobe coincides with the last character of the last line of the frame. It then expects the address on the next line to come from the old start value, and the new value to take effect only at the reload point the variant defines. A second overlap, specific to variant 2, puts the last-row capture, which loads the shadow from the start address, in the same frame as writes made in row 0 and in later rows. Every address is compared each clock against the bench's own model.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 14;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int IDX_W  = 5;

    localparam logic [IDX_W-1:0] IDX_HTOT     = 5'd0;
    localparam logic [IDX_W-1:0] IDX_HDISP    = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ROWS     = 5'd4;
    localparam logic [IDX_W-1:0] IDX_LINES    = 5'd9;
    localparam logic [IDX_W-1:0] IDX_START_HI = 5'd12;
    localparam logic [IDX_W-1:0] IDX_START_LO = 5'd13;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        VAR_PLAIN       = 2'd0,
        VAR_ROW0_LIVE   = 2'd1,
        VAR_BUF_PRELOAD = 2'd2,
        VAR_PLAIN_ALT   = 2'd3
    } variant_e;

    typedef struct packed {
        cnt_t htot;
        cnt_t hdisp;
        cnt_t rows;
        cnt_t lines;
    } tcfg_t;

    typedef struct packed {
        cnt_t hcc;
        cnt_t vlc;
        cnt_t vcc;
    } tpos_t;

    typedef struct packed {
        logic disp;
        logic line_end;
        logic frame_end;
        logic capture;
        logic cap_last_row;
        logic next_row0;
    } tev_t;

    function automatic addr_t join_start(logic [HI_W-1:0] hi, logic [DATA_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic is_plain(variant_e v);
        return (v == VAR_PLAIN) || (v == VAR_PLAIN_ALT);
    endfunction

endpackage

// File: rtl/vaddr_regs.sv
module vaddr_regs
    import vaddr_pkg::*;
#(
    parameter int HTOT_RST  = 7,
    parameter int HDISP_RST = 4,
    parameter int ROWS_RST  = 3,
    parameter int LINES_RST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    output tcfg_t             cfg,
    output addr_t             start_addr
);

    logic [IDX_W-1:0]  sel_q;
    tcfg_t             cfg_q;
    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.htot  <= cnt_t'(HTOT_RST);
            cfg_q.hdisp <= cnt_t'(HDISP_RST);
            cfg_q.rows  <= cnt_t'(ROWS_RST);
            cfg_q.lines <= cnt_t'(LINES_RST);
            hi_q        <= '0;
            lo_q        <= '0;
        end else if (data_we) begin
            case (sel_q)
                IDX_HTOT:     cfg_q.htot  <= wdata;
                IDX_HDISP:    cfg_q.hdisp <= wdata;
                IDX_ROWS:     cfg_q.rows  <= wdata;
                IDX_LINES:    cfg_q.lines <= wdata;
                IDX_START_HI: hi_q        <= wdata[HI_W-1:0];
                IDX_START_LO: lo_q        <= wdata;
                default: ;
            endcase
        end
    end

    assign cfg        = cfg_q;
    assign start_addr = join_start(hi_q, lo_q);

endmodule

// File: rtl/vaddr_raster.sv
module vaddr_raster
    import vaddr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tcfg_t cfg,
    output tpos_t pos,
    output tev_t  ev
);

    tpos_t pos_q;
    logic  row_end;

    always_comb begin
        ev.line_end     = (pos_q.hcc == cfg.htot);
        row_end         = ev.line_end && (pos_q.vlc == cfg.lines);
        ev.frame_end    = row_end && (pos_q.vcc == cfg.rows);
        ev.disp         = (pos_q.hcc < cfg.hdisp);
        ev.capture      = (pos_q.hcc == cfg.hdisp) && (pos_q.vlc == cfg.lines);
        ev.cap_last_row = ev.capture && (pos_q.vcc == cfg.rows);
        ev.next_row0    = ev.frame_end || ((pos_q.vcc == '0) && !row_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (ev.line_end) begin
            pos_q.hcc <= '0;
            if (row_end) begin
                pos_q.vlc <= '0;
                pos_q.vcc <= ev.frame_end ? '0 : pos_q.vcc + 1'b1;
            end else begin
                pos_q.vlc <= pos_q.vlc + 1'b1;
            end
        end else begin
            pos_q.hcc <= pos_q.hcc + 1'b1;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/vaddr_ptr.sv
module vaddr_ptr
    import vaddr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  variant_e variant,
    input  tev_t     ev,
    input  addr_t    start_addr,
    output addr_t    ma,
    output addr_t    ma_buf
);

    addr_t ma_q, buf_q, ma_n, buf_n;

    always_comb begin
        ma_n  = ma_q;
        buf_n = buf_q;
        if (ev.disp && !ev.line_end) begin
            ma_n = ma_q + 1'b1;
        end
        if (ev.capture) begin
            if (variant == VAR_BUF_PRELOAD && ev.cap_last_row) begin
                buf_n = start_addr;
            end else begin
                buf_n = ma_q;
            end
        end
        if (ev.line_end) begin
            unique case (variant)
                VAR_BUF_PRELOAD: begin
                    ma_n = buf_q;
                end
                VAR_ROW0_LIVE: begin
                    if (ev.next_row0) begin
                        ma_n = start_addr;
                        if (ev.frame_end) begin
                            buf_n = start_addr;
                        end
                    end else begin
                        ma_n = buf_q;
                    end
                end
                default: begin
                    if (is_plain(variant) && ev.frame_end) begin
                        ma_n  = start_addr;
                        buf_n = start_addr;
                    end else begin
                        ma_n = buf_q;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ma_q  <= '0;
            buf_q <= '0;
        end else begin
            ma_q  <= ma_n;
            buf_q <= buf_n;
        end
    end

    assign ma     = ma_q;
    assign ma_buf = buf_q;

endmodule

// File: rtl/vaddr_reload.sv
module vaddr_reload
    import vaddr_pkg::*;
#(
    parameter int HTOT_RST  = 7,
    parameter int HDISP_RST = 4,
    parameter int ROWS_RST  = 3,
    parameter int LINES_RST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        variant_sel,
    input  logic              reg_sel_we,
    input  logic              reg_data_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] vid_addr
);

    tcfg_t    cfg;
    addr_t    start_addr;
    tpos_t    pos;
    tev_t     ev;
    addr_t    ma_buf;
    variant_e variant;

    assign variant = variant_e'(variant_sel);

    vaddr_regs #(
        .HTOT_RST  (HTOT_RST),
        .HDISP_RST (HDISP_RST),
        .ROWS_RST  (ROWS_RST),
        .LINES_RST (LINES_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (reg_sel_we),
        .data_we    (reg_data_we),
        .wdata      (reg_wdata),
        .cfg        (cfg),
        .start_addr (start_addr)
    );

    vaddr_raster u_raster (
        .clk (clk),
        .rst (rst),
        .cfg (cfg),
        .pos (pos),
        .ev  (ev)
    );

    vaddr_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .variant    (variant),
        .ev         (ev),
        .start_addr (start_addr),
        .ma         (vid_addr),
        .ma_buf     (ma_buf)
    );

endmodule

// File: rtl/vaddr_reload_chk.sv
module vaddr_reload_chk
    import vaddr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] variant_sel,
    input addr_t      vid_addr,
    input addr_t      ma_buf,
    input addr_t      start_addr,
    input tpos_t      pos,
    input tcfg_t      cfg
);

    logic le, fe, cap, last_row;
    always_comb begin
        le       = (pos.hcc == cfg.htot);
        last_row = (pos.vcc == cfg.rows);
        fe       = le && (pos.vlc == cfg.lines) && last_row;
        cap      = (pos.hcc == cfg.hdisp) && (pos.vlc == cfg.lines) && !le;
    end

    // R3
    hwrap_chk: assert property (@(posedge clk) disable iff (rst)
        le |=> (pos.hcc == '0));

    // R3
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        fe |=> (pos.vlc == '0 && pos.vcc == '0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.hcc < cfg.hdisp && !le) |=> (vid_addr == $past(vid_addr) + 14'd1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.hcc >= cfg.hdisp && !le) |=> $stable(vid_addr));

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && !(variant_sel == 2'd2 && last_row)) |=> (ma_buf == $past(vid_addr)));

    // R6
    reload_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (le && (variant_sel == 2'd2 || (variant_sel != 2'd1 && !fe))) |=> (vid_addr == $past(ma_buf)));

    // R7
    plain_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (fe && (variant_sel == 2'd0 || variant_sel == 2'd3))
        |=> (vid_addr == $past(start_addr) && ma_buf == $past(start_addr)));

    // R8
    row0_live_chk: assert property (@(posedge clk) disable iff (rst)
        (le && variant_sel == 2'd1 && (fe || (pos.vcc == '0 && pos.vlc != cfg.lines)))
        |=> (vid_addr == $past(start_addr)));

    // R9
    preload_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && variant_sel == 2'd2 && last_row) |=> (ma_buf == $past(start_addr)));

endmodule

bind vaddr_reload vaddr_reload_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .variant_sel (variant_sel),
    .vid_addr    (vid_addr),
    .ma_buf      (ma_buf),
    .start_addr  (start_addr),
    .pos         (pos),
    .cfg         (cfg)
);

// File: tb/vaddr_reload_tb.sv
`timescale 1ns/1ps
module vaddr_reload_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  variant_sel = 2'd0;
    logic        reg_sel_we = 1'b0;
    logic        reg_data_we = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [13:0] vid_addr;

    int vectors = 0;
    int fails   = 0;
    bit started = 0;
    bit done    = 0;
    bit late_wr = 0;

    // behavioural reference state
    int mh, ml, mr, mma, mbuf;
    int c_htot, c_hdisp, c_rows, c_lines, shi, slo, msel;

    always #2.5 clk = ~clk;

    vaddr_reload u_dut (
        .clk         (clk),
        .rst         (rst),
        .variant_sel (variant_sel),
        .reg_sel_we  (reg_sel_we),
        .reg_data_we (reg_data_we),
        .reg_wdata   (reg_wdata),
        .vid_addr    (vid_addr)
    );

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            mh = 0; ml = 0; mr = 0; mma = 0; mbuf = 0;
            c_htot = 7; c_hdisp = 4; c_rows = 3; c_lines = 2;
            shi = 0; slo = 0; msel = 0;
        end else begin
            int st, nma, nbuf, nrow;
            bit eol, lastl, eof, grab;
            st    = shi * 256 + slo;
            eol   = (mh == c_htot);
            lastl = (ml == c_lines);
            eof   = eol && lastl && (mr == c_rows);
            grab  = (mh == c_hdisp) && lastl;
            nrow  = (eol && lastl) ? (eof ? 0 : (mr + 1) % 256) : mr;
            nma   = mma;
            nbuf  = mbuf;
            if (mh < c_hdisp && !eol) nma = (mma + 1) % 16384;
            if (grab) nbuf = (variant_sel == 2 && mr == c_rows) ? st : mma;
            if (eol) begin
                if (variant_sel == 2) nma = mbuf;
                else if (variant_sel == 1 && nrow == 0) begin
                    nma = st;
                    if (eof) nbuf = st;
                end else if (variant_sel != 1 && eof) begin
                    nma = st; nbuf = st;
                end else nma = mbuf;
            end
            mma = nma; mbuf = nbuf;
            if (eol) begin
                mh = 0;
                if (lastl) begin ml = 0; mr = nrow; end
                else ml = (ml + 1) % 256;
            end else mh = (mh + 1) % 256;
            if (reg_data_we) begin
                case (msel)
                    0:  c_htot  = reg_wdata;
                    1:  c_hdisp = reg_wdata;
                    4:  c_rows  = reg_wdata;
                    9:  c_lines = reg_wdata;
                    12: shi     = reg_wdata % 64;
                    13: slo     = reg_wdata;
                    default: ;
                endcase
            end
            if (reg_sel_we) msel = reg_wdata % 32;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            string tag;
            if (rst) tag = "R1";
            else if (late_wr) tag = "R10";
            else if (mh == 0 && ml == 0 && mr == 0)
                tag = (variant_sel == 2) ? "R9" : (variant_sel == 1) ? "R8" : "R3/R7";
            else if (mh == 0 && variant_sel == 1 && mr == 0) tag = "R8";
            else if (mh == 0 && ml == 0) tag = "R5";
            else if (mh == 0) tag = "R6";
            else tag = "R2/R4";
            vectors++;
            if (vid_addr !== 14'(mma)) begin
                fails++;
                $display("FAIL %s: variant %0d h=%0d l=%0d r=%0d actual %h expected %h",
                         tag, variant_sel, mh, ml, mr, vid_addr, 14'(mma));
            end
            if (!rst) late_wr = 0;
        end
    end

    task automatic wr(input int idx, input int val);
        @(negedge clk); reg_sel_we = 1; reg_wdata = 8'(idx);
        @(negedge clk); reg_sel_we = 0; reg_data_we = 1; reg_wdata = 8'(val);
        @(negedge clk); reg_data_we = 0;
    endtask

    // data strobe lands on the edge that ends the frame (R10)
    task automatic wr_at_frame_end(input int idx, input int val);
        @(negedge clk);
        while (!(mh == c_htot - 1 && ml == c_lines && mr == c_rows)) @(negedge clk);
        reg_sel_we = 1; reg_wdata = 8'(idx);
        @(negedge clk); reg_sel_we = 0; reg_data_we = 1; reg_wdata = 8'(val);
        late_wr = 1;
        @(negedge clk); reg_data_we = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            rst = 1; variant_sel = 2'(v);
            run(3);
            rst = 0;
            if (v == 3) begin
                // R2: reprogram timing through the indirect port
                wr(0, 9); wr(1, 3); wr(9, 1); wr(4, 2);
            end
            run(100);
            // write start address with row counter non-zero
            while (mr != 2) @(negedge clk);
            wr(12, 8'h12); wr(13, 8'h34 + v);
            run(250);
            // write during row 0 (R8 shows it on next line)
            while (!(mr == 0 && ml == 0 && mh == 2)) @(negedge clk);
            wr(13, 8'h80);
            run(250);
            // collision with frame-start reload, near top of address space
            wr(12, 8'h3F);
            wr_at_frame_end(13, 8'hFE);
            run(300);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule